// File: doc/BRIEF.md
# Codeword Pulse Playback Unit

This block keeps a small table of calibrated pulse envelopes and plays one of them out whenever a codeword trigger arrives. The codeword selects the table entry. Each entry is one primitive operation, stored as a fixed number of steps. Each step carries a group of in-phase samples and a group of quadrature samples. Longer operation sequences are built by timing the triggers. Whole waveforms are never uploaded.

A host loads the table through a simple write port before a run. During a run, a trigger strobe with a codeword is captured on a clock edge. After a fixed, deterministic latency the selected pulse appears on two sample buses, I and Q, with a valid strobe. When a trigger arrives while an earlier pulse is still in progress, the earlier pulse is cut short at the point where the new one starts, and an abort strobe is raised. Codeword 0 is the identity operation. It plays zeros and cannot be overwritten.

The default build uses 8 codewords, 14-bit samples, 2 samples per lane per cycle, 4-cycle pulses and a 16-cycle latency (80 ns at 200 MHz). The intended codeword assignment is: identity 0, X by π 1, X by π/2 2, X by −π/2 3, Y by π 4, Y by π/2 5, Y by −π/2 6. Codeword 7 is spare.

Top module: `cwp_player`

## Requirements
- R1: The table is indexed by codeword. Each entry holds PULSE_LEN steps. A pulse presents its steps in order, 0 to PULSE_LEN-1, one step per cycle, and valid_o is high for exactly PULSE_LEN cycles.
- R2: After reset, and in every cycle in which no pulse is presented, valid_o and abort_o are low and both sample buses are all zeros. Table entries reset to zero.
- R3: I and Q are separate streams. Within a bus, lane k occupies bits [k*SAMPLE_W +: SAMPLE_W], and lane 0 is the earliest sample of the step.
- R4: A trigger captured at clock edge n presents step 0 at the output right after edge n+LATENCY. Nothing is presented for it before that edge.
- R5: Triggers spaced exactly PULSE_LEN cycles apart give pulses with valid_o held high continuously and no abort.
- R6: Codeword 0 presents all-zero samples with valid_o high. Writes addressed to codeword 0 are ignored.
- R7: If a pulse's step 0 is due while an earlier pulse still has steps left, the earlier pulse stops and the new one starts on schedule. abort_o is high for exactly that one cycle, together with the new step 0.
- R8: A write is ignored when, at its capture edge, any captured trigger has not yet reached the output or a pulse still has steps left to present. A trigger captured on the same edge as the write does not count.
- R9: A write captured while idle, with wr_en_i high, stores wr_i_data_i and wr_q_data_i as step wr_step_i of codeword wr_cw_i. A later pulse for that codeword presents the stored samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_cw_i | input | CW_W (3) | Codeword of the entry to write |
| wr_step_i | input | STEP_W (2) | Step within the entry |
| wr_i_data_i | input | SPC*SAMPLE_W (28) | In-phase samples for the step |
| wr_q_data_i | input | SPC*SAMPLE_W (28) | Quadrature samples for the step |
| trig_i | input | 1 | Trigger strobe |
| trig_cw_i | input | CW_W (3) | Codeword to play |
| i_data_o | output | SPC*SAMPLE_W (28) | In-phase sample bus |
| q_data_o | output | SPC*SAMPLE_W (28) | Quadrature sample bus |
| valid_o | output | 1 | Samples valid |
| abort_o | output | 1 | Earlier pulse cut short by this one |

## Verification
Some properties are checked on every cycle. Idle outputs must be zero. A pulse in progress must not leave a gap before its last step. An abort must coincide with a presented sample that follows a presented sample. Table entries must hold while the unit is busy. The identity codeword must play zeros. The exact trigger-to-output latency, the step order, the lane packing, and whether a write was dropped or stored can only be seen in the bench's scenarios. The bench compares every output cycle against a cycle model built from the requirements, and it reads back the table contents through later playback.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
  localparam int unsigned CW_IDENTITY = 0;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cwp_delay_line.sv
module cwp_delay_line #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW_W  = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trig_i,
  input  logic [CW_W-1:0] cw_i,
  output logic            vld_o,
  output logic [CW_W-1:0] cw_o,
  output logic            pending_o
);
  logic [DEPTH-1:0] vld_q;
  logic [CW_W-1:0]  cw_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int k = 0; k < DEPTH; k++) cw_q[k] <= '0;
    end else begin
      for (int k = DEPTH - 1; k > 0; k--) begin
        vld_q[k] <= vld_q[k-1];
        cw_q[k]  <= cw_q[k-1];
      end
      vld_q[0] <= trig_i;
      cw_q[0]  <= cw_i;
    end
  end

  assign vld_o     = vld_q[DEPTH-1];
  assign cw_o      = cw_q[DEPTH-1];
  assign pending_o = |vld_q;
endmodule

// File: rtl/cwp_table.sv
module cwp_table #(
  parameter int unsigned NUM_CW    = 8,
  parameter int unsigned PULSE_LEN = 4,
  parameter int unsigned LANE_W    = 28,
  parameter int unsigned CW_W      = 3,
  parameter int unsigned STEP_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              wr_en_i,
  input  logic [CW_W-1:0]   wr_cw_i,
  input  logic [STEP_W-1:0] wr_step_i,
  input  logic [LANE_W-1:0] wr_i_i,
  input  logic [LANE_W-1:0] wr_q_i,
  input  logic [CW_W-1:0]   rd_cw_i,
  input  logic [STEP_W-1:0] rd_step_i,
  output logic [LANE_W-1:0] rd_i_o,
  output logic [LANE_W-1:0] rd_q_o
);
  import cwp_pkg::*;

  localparam int unsigned DEPTH = NUM_CW * PULSE_LEN;
  localparam int unsigned IDX_W = idx_w(DEPTH);

  logic [LANE_W-1:0] mem_i_q [DEPTH];
  logic [LANE_W-1:0] mem_q_q [DEPTH];

  logic            wr_fire;
  logic            rd_ok;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  assign wr_fire = wr_en_i && !busy_i
                && (int'(wr_cw_i) != CW_IDENTITY)
                && (int'(wr_cw_i) < NUM_CW)
                && (int'(wr_step_i) < PULSE_LEN);
  assign wr_idx  = IDX_W'(int'(wr_cw_i) * PULSE_LEN + int'(wr_step_i));
  assign rd_idx  = IDX_W'(int'(rd_cw_i) * PULSE_LEN + int'(rd_step_i));
  assign rd_ok   = (int'(rd_cw_i) != CW_IDENTITY)
                && (int'(rd_cw_i) < NUM_CW)
                && (int'(rd_step_i) < PULSE_LEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) begin
        mem_i_q[e] <= '0;
        mem_q_q[e] <= '0;
      end
    end else if (wr_fire) begin
      mem_i_q[wr_idx] <= wr_i_i;
      mem_q_q[wr_idx] <= wr_q_i;
    end
  end

  always_comb begin
    rd_i_o = '0;
    rd_q_o = '0;
    if (rd_ok) begin
      rd_i_o = mem_i_q[rd_idx];
      rd_q_o = mem_q_q[rd_idx];
    end
  end

  // R8: entries are frozen across any busy edge
  for (genvar e = 0; e < DEPTH; e++) begin : g_hold_chk
    assert_hold_when_busy_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_i |=> ($stable(mem_i_q[e]) && $stable(mem_q_q[e])));
  end
endmodule

// File: rtl/cwp_sequencer.sv
module cwp_sequencer #(
  parameter int unsigned PULSE_LEN = 4,
  parameter int unsigned CW_W      = 3,
  parameter int unsigned STEP_W    = 2,
  parameter int unsigned LANE_W    = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CW_W-1:0]   start_cw_i,
  output logic [CW_W-1:0]   rd_cw_o,
  output logic [STEP_W-1:0] rd_step_o,
  input  logic [LANE_W-1:0] rd_i_i,
  input  logic [LANE_W-1:0] rd_q_i,
  output logic [LANE_W-1:0] i_data_o,
  output logic [LANE_W-1:0] q_data_o,
  output logic              valid_o,
  output logic              abort_o,
  output logic              active_o,
  output logic [CW_W-1:0]   cur_cw_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PULSE_LEN - 1);

  logic              active_q;
  logic [CW_W-1:0]   cw_q;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_after_start;
  logic              continues_after_start;

  if (PULSE_LEN > 1) begin : g_multi
    assign step_after_start      = STEP_W'(1);
    assign continues_after_start = 1'b1;
  end else begin : g_single
    assign step_after_start      = '0;
    assign continues_after_start = 1'b0;
  end

  assign rd_cw_o   = start_i ? start_cw_i : cw_q;
  assign rd_step_o = start_i ? '0 : step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cw_q     <= '0;
      step_q   <= '0;
      valid_o  <= 1'b0;
      abort_o  <= 1'b0;
      i_data_o <= '0;
      q_data_o <= '0;
    end else if (start_i) begin
      abort_o  <= active_q;  // earlier pulse still had steps
      active_q <= continues_after_start;
      cw_q     <= start_cw_i;
      step_q   <= step_after_start;
      valid_o  <= 1'b1;
      i_data_o <= rd_i_i;
      q_data_o <= rd_q_i;
    end else if (active_q) begin
      abort_o  <= 1'b0;
      valid_o  <= 1'b1;
      i_data_o <= rd_i_i;
      q_data_o <= rd_q_i;
      step_q   <= step_q + STEP_W'(1);
      if (step_q == LAST_STEP) active_q <= 1'b0;
    end else begin
      abort_o  <= 1'b0;
      valid_o  <= 1'b0;
      i_data_o <= '0;
      q_data_o <= '0;
    end
  end

  assign active_o = active_q;
  assign cur_cw_o = cw_q;

  assert_idle_zero_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (i_data_o == '0 && q_data_o == '0 && !abort_o));

  assert_no_gap_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |=> valid_o);

  assert_abort_on_sample_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> valid_o);

  assert_abort_follows_play_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(valid_o));
endmodule

// File: rtl/cwp_player.sv
module cwp_player #(
  parameter int unsigned NUM_CW    = 8,
  parameter int unsigned SAMPLE_W  = 14,
  parameter int unsigned SPC       = 2,
  parameter int unsigned PULSE_LEN = 4,
  parameter int unsigned LATENCY   = 16,
  localparam int unsigned CW_W     = cwp_pkg::idx_w(NUM_CW),
  localparam int unsigned STEP_W   = cwp_pkg::idx_w(PULSE_LEN),
  localparam int unsigned LANE_W   = SPC * SAMPLE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CW_W-1:0]   wr_cw_i,
  input  logic [STEP_W-1:0] wr_step_i,
  input  logic [LANE_W-1:0] wr_i_data_i,
  input  logic [LANE_W-1:0] wr_q_data_i,
  input  logic              trig_i,
  input  logic [CW_W-1:0]   trig_cw_i,
  output logic [LANE_W-1:0] i_data_o,
  output logic [LANE_W-1:0] q_data_o,
  output logic              valid_o,
  output logic              abort_o
);
  import cwp_pkg::*;

  logic              start, pending, active, busy;
  logic [CW_W-1:0]   start_cw, rd_cw, cur_cw;
  logic [STEP_W-1:0] rd_step;
  logic [LANE_W-1:0] rd_i, rd_q;

  // LATENCY stages then the output register: step 0 lands LATENCY edges after capture
  cwp_delay_line #(.DEPTH(LATENCY), .CW_W(CW_W)) u_delay (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig_i),
    .cw_i      (trig_cw_i),
    .vld_o     (start),
    .cw_o      (start_cw),
    .pending_o (pending)
  );

  assign busy = pending | active;

  cwp_table #(
    .NUM_CW(NUM_CW), .PULSE_LEN(PULSE_LEN), .LANE_W(LANE_W),
    .CW_W(CW_W), .STEP_W(STEP_W)
  ) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy),
    .wr_en_i   (wr_en_i),
    .wr_cw_i   (wr_cw_i),
    .wr_step_i (wr_step_i),
    .wr_i_i    (wr_i_data_i),
    .wr_q_i    (wr_q_data_i),
    .rd_cw_i   (rd_cw),
    .rd_step_i (rd_step),
    .rd_i_o    (rd_i),
    .rd_q_o    (rd_q)
  );

  cwp_sequencer #(
    .PULSE_LEN(PULSE_LEN), .CW_W(CW_W), .STEP_W(STEP_W), .LANE_W(LANE_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .start_cw_i (start_cw),
    .rd_cw_o    (rd_cw),
    .rd_step_o  (rd_step),
    .rd_i_i     (rd_i),
    .rd_q_i     (rd_q),
    .i_data_o   (i_data_o),
    .q_data_o   (q_data_o),
    .valid_o    (valid_o),
    .abort_o    (abort_o),
    .active_o   (active),
    .cur_cw_o   (cur_cw)
  );

  assert_identity_zero_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && int'(cur_cw) == CW_IDENTITY) |-> (i_data_o == '0 && q_data_o == '0));
endmodule

// File: tb/cwp_player_test.sv
module cwp_player_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CW     = 8;
  localparam int SAMPLE_W   = 14;
  localparam int SPC        = 2;
  localparam int PULSE_LEN  = 4;
  localparam int LATENCY    = 16;
  localparam int CW_W       = 3;
  localparam int STEP_W     = 2;
  localparam int LANE_W     = SPC * SAMPLE_W;
  localparam int MAXT       = 96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [CW_W-1:0] wr_cw = '0;
  logic [STEP_W-1:0] wr_step = '0;
  logic [LANE_W-1:0] wr_i = '0, wr_q = '0;
  logic trig = 1'b0;
  logic [CW_W-1:0] trig_cw = '0;
  logic [LANE_W-1:0] i_data, q_data;
  logic valid, abort_s;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // stimulus schedule, indexed by capture edge
  bit              tr_en [MAXT];
  int              tr_cw [MAXT];
  bit              w_en  [MAXT];
  int              w_cw  [MAXT];
  int              w_st  [MAXT];
  logic [LANE_W-1:0] w_i [MAXT];
  logic [LANE_W-1:0] w_q [MAXT];

  // table contents expected from the requirements
  logic [LANE_W-1:0] tb_i [NUM_CW][PULSE_LEN];
  logic [LANE_W-1:0] tb_q [NUM_CW][PULSE_LEN];

  always #(CLK_PERIOD/2) clk = ~clk;

  cwp_player uut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_cw_i(wr_cw), .wr_step_i(wr_step),
    .wr_i_data_i(wr_i), .wr_q_data_i(wr_q),
    .trig_i(trig), .trig_cw_i(trig_cw),
    .i_data_o(i_data), .q_data_o(q_data),
    .valid_o(valid), .abort_o(abort_s)
  );

  function automatic logic [LANE_W-1:0] pat(int cw, int st, int ver, bit q);
    logic [LANE_W-1:0] v;
    for (int l = 0; l < SPC; l++)
      v[l*SAMPLE_W +: SAMPLE_W] = {(q ? 2'b10 : 2'b01), 4'(cw), 4'(st), 2'(ver), 2'(l)};
    return v;
  endfunction

  task automatic chk(bit ok, string req, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  task automatic clr();
    for (int t = 0; t < MAXT; t++) begin
      tr_en[t] = 0; tr_cw[t] = 0; w_en[t] = 0; w_cw[t] = 0; w_st[t] = 0;
      w_i[t] = '0; w_q[t] = '0;
    end
  endtask

  // drives the schedule and compares each output cycle with a requirement model
  task automatic run_seq(int n, string req);
    bit m_vld = 0, m_abort = 0, m_active = 0;
    int m_cw = 0, m_step = 0, m_next = 0;
    for (int t = 0; t <= n; t++) begin
      @(negedge clk);
      if (t > 0) begin
        int e = t - 1;
        bit busy = m_active;
        bit start;
        logic [LANE_W-1:0] ei, eq;
        for (int s = e - LATENCY; s < e; s++) if (s >= 0 && tr_en[s]) busy = 1;
        start = (e >= LATENCY) && tr_en[e - LATENCY];
        if (start) begin
          m_abort = m_active; m_cw = tr_cw[e - LATENCY]; m_step = 0;
          m_vld = 1; m_active = (PULSE_LEN > 1); m_next = 1;
        end else if (m_active) begin
          m_abort = 0; m_step = m_next; m_vld = 1; m_next++;
          if (m_step == PULSE_LEN - 1) m_active = 0;
        end else begin
          m_vld = 0; m_abort = 0;
        end
        ei = m_vld ? tb_i[m_cw][m_step] : '0;
        eq = m_vld ? tb_q[m_cw][m_step] : '0;
        if (w_en[e] && !busy && w_cw[e] != 0) begin
          tb_i[w_cw[e]][w_st[e]] = w_i[e];
          tb_q[w_cw[e]][w_st[e]] = w_q[e];
        end
        chk(valid === m_vld && abort_s === m_abort && i_data === ei && q_data === eq, req,
            $sformatf("edge %0d: got v=%b a=%b i=%h q=%h exp v=%b a=%b i=%h q=%h",
                      e, valid, abort_s, i_data, q_data, m_vld, m_abort, ei, eq));
      end
      if (t < n) begin
        trig = tr_en[t]; trig_cw = CW_W'(tr_cw[t]);
        wr_en = w_en[t]; wr_cw = CW_W'(w_cw[t]); wr_step = STEP_W'(w_st[t]);
        wr_i = w_i[t]; wr_q = w_q[t];
      end else begin
        trig = 0; wr_en = 0;
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(valid === 1'b0 && abort_s === 1'b0 && i_data === '0 && q_data === '0, "R2",
        $sformatf("reset: got v=%b a=%b i=%h q=%h exp 0 0 0 0", valid, abort_s, i_data, q_data));
  endtask

  task automatic t_load();  // R9 idle writes, R6 identity writes dropped
    clr();
    for (int c = 0; c < NUM_CW; c++)
      for (int s = 0; s < PULSE_LEN; s++) begin
        int t = c * PULSE_LEN + s;
        w_en[t] = 1; w_cw[t] = c; w_st[t] = s;
        w_i[t] = pat(c, s, 0, 0); w_q[t] = pat(c, s, 0, 1);
      end
    run_seq(NUM_CW * PULSE_LEN + 2, "R9 R6");
  endtask

  task automatic t_single();  // R1 R3 R4
    clr();
    tr_en[0] = 1; tr_cw[0] = 1;
    run_seq(LATENCY + PULSE_LEN + 4, "R1 R3 R4");
  endtask

  task automatic t_chain();  // R5 back to back, R6 identity plays zeros
    int cws[7] = '{2, 3, 4, 5, 6, 0, 7};
    clr();
    for (int k = 0; k < 7; k++) begin
      tr_en[k * PULSE_LEN] = 1; tr_cw[k * PULSE_LEN] = cws[k];
    end
    run_seq(7 * PULSE_LEN + LATENCY + 4, "R5 R6");
  endtask

  task automatic t_abort();  // R7
    clr();
    tr_en[0] = 1; tr_cw[0] = 4;
    tr_en[2] = 1; tr_cw[2] = 5;
    tr_en[3] = 1; tr_cw[3] = 6;
    tr_en[12] = 1; tr_cw[12] = 1;
    tr_en[13] = 1; tr_cw[13] = 2;
    run_seq(13 + LATENCY + PULSE_LEN + 4, "R7");
  endtask

  task automatic t_busy();  // R8 drops, R9 accepted when idle again
    clr();
    tr_en[0] = 1; tr_cw[0] = 3;
    w_en[5] = 1;  w_cw[5] = 3;  w_st[5] = 0;  w_i[5] = pat(3, 0, 1, 0);  w_q[5] = pat(3, 0, 1, 1);
    w_en[18] = 1; w_cw[18] = 3; w_st[18] = 1; w_i[18] = pat(3, 1, 2, 0); w_q[18] = pat(3, 1, 2, 1);
    w_en[21] = 1; w_cw[21] = 3; w_st[21] = 2; w_i[21] = pat(3, 2, 3, 0); w_q[21] = pat(3, 2, 3, 1);
    tr_en[22] = 1; tr_cw[22] = 3;
    run_seq(22 + LATENCY + PULSE_LEN + 4, "R8 R9");
    // direct check: step 2 of codeword 3 now carries version 3 data
    chk(tb_i[3][2] === pat(3, 2, 3, 0) && tb_i[3][0] === pat(3, 0, 0, 0), "R8",
        $sformatf("model table i=%h/%h exp %h/%h", tb_i[3][2], tb_i[3][0],
                  pat(3, 2, 3, 0), pat(3, 0, 0, 0)));
  endtask

  initial begin
    for (int c = 0; c < NUM_CW; c++)
      for (int s = 0; s < PULSE_LEN; s++) begin tb_i[c][s] = '0; tb_q[c][s] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();   // before load: entries reset to zero (R2)
    t_load();
    t_single();
    t_chain();
    t_abort();
    t_busy();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule